// File: doc/BRIEF.md
# Link acknowledge and replay controller

This block gives a point-to-point serial link reliable, in-order delivery of fixed-size payloads. On the transmit side, each payload accepted from the local user receives the next 8-bit frame identifier. A copy is placed in a 32-entry replay store, and the payload is sent in the next free outgoing frame slot. The peer's acknowledgements are cumulative: one acknowledgement releases every stored copy up to and including the identifier it names. A replay request from the peer rewinds transmission to the oldest copy that has not been acknowledged, and every frame from that point on is sent again.

On the receive side, the block tracks the identifier it expects next. It accepts only a clean, acknowledgeable frame that carries that identifier. It reports the last good identifier back to the peer one bit per outgoing frame, through the single acknowledge bit that every frame carries, whether or not that frame has a payload. A CRC failure produces a replay request and increments a saturating error count, which software can read to decide whether to retrain the link. CRC generation and checking and the lane logic are outside this block; the block only sees a per-frame CRC verdict.

The acknowledge channel is framed in 10-bit groups that are sent least significant bit first over successive frames. A group is a start bit of 1, then eight identifier bits with the LSB first, then a closing bit. The closing bit is 0 for an acknowledgement. A replay request has all eight data bits at 1 and a closing bit of 1. Between groups the acknowledge bit is 0.

Top module: `ackrep_ctrl`

## Requirements
- R1: After reset, `tx_ready_o` is 1, the replay store is empty (a slot carries no payload), `frm_ack_o` is 0 and `crc_err_cnt_o` is 0.
- R2: Accepted payloads are emitted in acceptance order, one per cycle with `slot_i` high, with `frm_fid_o` starting at 0 after reset and incrementing by one per emitted acknowledgeable frame. `frm_vld_o` is never high without `slot_i`.
- R3: The replay store holds at most 32 unacknowledged payloads. `tx_ready_o` is 0 while 32 are held and returns to 1 once an acknowledgement frees an entry.
- R4: A received acknowledgement group (bits 1, id[0..7], 0 on successive `rx_slot_i` frames with `rx_crc_ok_i` high) releases every held entry up to and including `id`. It is honoured only if (id − oldest) mod 256 < 128 and id is not newer than the last accepted payload; any other acknowledgement is ignored.
- R5: A received replay group (bits 1, eight 1s, 1) makes the next emitted frame the oldest unacknowledged entry, and emission continues in order from there.
- R6: An acknowledge bit received in a frame with `rx_crc_ok_i` low is discarded, and the group in progress is abandoned without effect.
- R7: `rx_acc_o` pulses only for a frame with `rx_slot_i`, `rx_crc_ok_i` and `rx_vld_i` high and `rx_fid_i` equal to the expected identifier, which starts at 0 and then advances by one. Other frames are dropped.
- R8: Whenever the last good received identifier changes, the block sends an acknowledgement group carrying the newest such identifier on `frm_ack_o`, one bit per `slot_i` cycle, whether or not `frm_vld_o` is high. `frm_ack_o` is 0 when no group is in progress.
- R9: A frame with `rx_crc_ok_i` low causes one replay group (1, eight 1s, 1), which is sent ahead of any pending acknowledgement group. Further CRC failures send no more replay groups until an expected frame has been accepted.
- R10: `crc_err_cnt_o` counts frames with `rx_crc_ok_i` low and saturates at 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid_i | input | 1 | Payload offered for transmission |
| tx_data_i | input | 72 | Payload to transmit |
| tx_ready_o | output | 1 | Replay store can take a payload |
| slot_i | input | 1 | An outgoing frame is formed this cycle |
| frm_vld_o | output | 1 | Outgoing frame carries an acknowledgeable payload |
| frm_fid_o | output | 8 | Identifier of the outgoing payload |
| frm_data_o | output | 72 | Outgoing payload |
| frm_ack_o | output | 1 | Acknowledge bit of the outgoing frame |
| rx_slot_i | input | 1 | An incoming frame is present this cycle |
| rx_crc_ok_i | input | 1 | Incoming frame passed its CRC check |
| rx_vld_i | input | 1 | Incoming frame carries an acknowledgeable payload |
| rx_fid_i | input | 8 | Identifier of the incoming payload |
| rx_ack_i | input | 1 | Acknowledge bit of the incoming frame |
| rx_acc_o | output | 1 | Incoming payload accepted in order |
| crc_err_cnt_o | output | 16 | Saturating count of CRC failures |

## Verification
On every cycle, the assertions check the store occupancy bound and back-pressure, that frame validity is tied to a slot, the single-step advance of the expected identifier, the rewind performed on a replay request and the step and saturation of the error count. The cumulative release and the modulo window for acknowledgements, the discarding of acknowledge bits from corrupt frames, the bit order of outgoing groups, replay priority and the one-request-per-episode rule all depend on sequences of frames. Only the directed scenarios can show these: they send groups bit by bit and then probe the store through a replay.

// File: rtl/ackrep_ctrl.sv
module ackrep_ctrl #(
  parameter int PW    = 72,
  parameter int DEPTH = 32,
  parameter int CW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_valid_i,
  input  logic [PW-1:0] tx_data_i,
  output logic          tx_ready_o,
  input  logic          slot_i,
  output logic          frm_vld_o,
  output logic [7:0]    frm_fid_o,
  output logic [PW-1:0] frm_data_o,
  output logic          frm_ack_o,
  input  logic          rx_slot_i,
  input  logic          rx_crc_ok_i,
  input  logic          rx_vld_i,
  input  logic [7:0]    rx_fid_i,
  input  logic          rx_ack_i,
  output logic          rx_acc_o,
  output logic [CW-1:0] crc_err_cnt_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [7:0] DEPTH8 = 8'(DEPTH);

  logic [PW-1:0] mem [DEPTH];
  logic [7:0] head_q, send_q, tail_q;
  logic [3:0] dcnt_q;
  logic [7:0] dsh_q;

  wire [7:0] used = tail_q - head_q;
  assign tx_ready_o = used < DEPTH8;
  wire push = tx_valid_i & tx_ready_o;
  assign frm_vld_o  = slot_i & (send_q != tail_q);
  assign frm_fid_o  = send_q;
  assign frm_data_o = mem[send_q[AW-1:0]];

  wire rbit_ok = rx_slot_i & rx_crc_ok_i;
  wire grp_end = rbit_ok & (dcnt_q == 4'd9);
  wire got_ack = grp_end & ~rx_ack_i;
  wire got_rp  = grp_end & rx_ack_i & (dsh_q == 8'hFF);
  wire [7:0] nhead = dsh_q + 8'd1;
  wire [7:0] a_off = dsh_q - head_q;
  wire [7:0] a_lim = tail_q - 8'd1 - dsh_q;
  wire ack_ok = got_ack & ~a_off[7] & ~a_lim[7];
  wire [7:0] s_off = send_q - nhead;

  always_ff @(posedge clk)
    if (push) mem[tail_q[AW-1:0]] <= tx_data_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      send_q <= '0;
      tail_q <= '0;
      dcnt_q <= '0;
      dsh_q  <= '0;
    end else begin
      if (push) tail_q <= tail_q + 8'd1;
      if (ack_ok) head_q <= nhead;
      if (got_rp) send_q <= head_q;
      else if (ack_ok && s_off[7]) send_q <= nhead;
      else if (frm_vld_o) send_q <= send_q + 8'd1;
      if (rx_slot_i) begin
        if (!rx_crc_ok_i) dcnt_q <= '0;
        else if (dcnt_q == 4'd0) begin
          if (rx_ack_i) dcnt_q <= 4'd1;
        end else if (dcnt_q == 4'd9) dcnt_q <= '0;
        else begin
          dsh_q  <= {rx_ack_i, dsh_q[7:1]};
          dcnt_q <= dcnt_q + 4'd1;
        end
      end
    end
  end

  logic [7:0] exp_q, sent_q;
  logic wait_q, rpreq_q;
  logic [CW-1:0] err_q;
  logic [3:0] scnt_q;
  logic [9:0] ssh_q;

  assign rx_acc_o = rbit_ok & rx_vld_i & (rx_fid_i == exp_q);
  wire bad = rx_slot_i & ~rx_crc_ok_i;
  wire [7:0] last_good = exp_q - 8'd1;
  wire s_idle = scnt_q == 4'd0;
  assign frm_ack_o = ~s_idle & ssh_q[0];
  assign crc_err_cnt_o = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_q   <= '0;
      sent_q  <= 8'hFF;
      wait_q  <= 1'b0;
      rpreq_q <= 1'b0;
      err_q   <= '0;
      scnt_q  <= '0;
      ssh_q   <= '0;
    end else begin
      if (s_idle) begin
        if (rpreq_q) begin
          ssh_q   <= 10'h3FF;
          scnt_q  <= 4'd10;
          rpreq_q <= 1'b0;
        end else if (last_good != sent_q) begin
          ssh_q  <= {1'b0, last_good, 1'b1};
          scnt_q <= 4'd10;
          sent_q <= last_good;
        end
      end else if (slot_i) begin
        ssh_q  <= ssh_q >> 1;
        scnt_q <= scnt_q - 4'd1;
      end
      if (rx_acc_o) begin
        exp_q  <= exp_q + 8'd1;
        wait_q <= 1'b0;
      end
      if (bad) begin
        if (~&err_q) err_q <= err_q + 1'b1;
        if (!wait_q) begin
          wait_q  <= 1'b1;
          rpreq_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ackrep_ctrl_chk.sv
module ackrep_ctrl_chk #(
  parameter int DEPTH = 32,
  parameter int CW    = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_ready_o,
  input logic          slot_i,
  input logic          frm_vld_o,
  input logic          rx_acc_o,
  input logic          rx_slot_i,
  input logic          rx_crc_ok_i,
  input logic [7:0]    head_q,
  input logic [7:0]    send_q,
  input logic [7:0]    tail_q,
  input logic [7:0]    exp_q,
  input logic          got_rp,
  input logic [CW-1:0] err_q
);
  // R3
  fill_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (8'(tail_q - head_q) <= 8'(DEPTH)));
  // R3
  hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready_o |=> tail_q == $past(tail_q));
  // R2
  slot_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld_o |-> slot_i);
  // R7
  acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_acc_o |=> exp_q == 8'($past(exp_q) + 8'd1));
  // R5
  rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    got_rp |=> send_q == $past(head_q));
  // R10
  err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_slot_i && !rx_crc_ok_i && err_q != '1) |=> err_q == CW'($past(err_q) + 1'b1));
  // R10
  err_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q == '1) |=> (err_q == '1));
endmodule

bind ackrep_ctrl ackrep_ctrl_chk #(.DEPTH(DEPTH), .CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .tx_ready_o(tx_ready_o), .slot_i(slot_i),
  .frm_vld_o(frm_vld_o), .rx_acc_o(rx_acc_o), .rx_slot_i(rx_slot_i),
  .rx_crc_ok_i(rx_crc_ok_i), .head_q(head_q), .send_q(send_q),
  .tail_q(tail_q), .exp_q(exp_q), .got_rp(got_rp), .err_q(err_q)
);

// File: tb/test_ackrep_ctrl.sv
module test_ackrep_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 72;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_valid_i = 0, slot_i = 0, rx_slot_i = 0, rx_crc_ok_i = 0, rx_vld_i = 0, rx_ack_i = 0;
  logic [PW-1:0] tx_data_i = '0;
  logic [7:0] rx_fid_i = '0;
  logic tx_ready_o, frm_vld_o, frm_ack_o, rx_acc_o;
  logic [7:0] frm_fid_o;
  logic [PW-1:0] frm_data_o;
  logic [15:0] crc_err_cnt_o;
  int n_chk = 0, n_bad = 0;

  ackrep_ctrl i_ackrep_ctrl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; tx_valid_i = 0; slot_i = 0; rx_slot_i = 0; rx_crc_ok_i = 0;
    rx_vld_i = 0; rx_ack_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic push(input int k, output logic rdy);
    @(negedge clk); tx_valid_i = 1; tx_data_i = PW'(1000 + k);
    #1 rdy = tx_ready_o;
    @(posedge clk); #1 tx_valid_i = 0;
  endtask

  task automatic emit(output logic v, output logic [7:0] fid, output longint d);
    @(negedge clk); slot_i = 1;
    #1 v = frm_vld_o; fid = frm_fid_o; d = longint'(frm_data_o[63:0]);
    @(posedge clk); #1 slot_i = 0;
  endtask

  task automatic send_group(input logic [7:0] id, input logic stop, input int badpos);
    logic [9:0] g;
    g = {stop, id, 1'b1};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); rx_slot_i = 1; rx_crc_ok_i = (i != badpos); rx_vld_i = 0; rx_ack_i = g[i];
      @(posedge clk); #1 rx_slot_i = 0; rx_ack_i = 0;
    end
  endtask

  task automatic rx_frame(input logic [7:0] fid, input logic ok, input logic vld, output logic acc);
    @(negedge clk); rx_slot_i = 1; rx_crc_ok_i = ok; rx_vld_i = vld; rx_fid_i = fid; rx_ack_i = 0;
    #1 acc = rx_acc_o;
    @(posedge clk); #1 rx_slot_i = 0;
  endtask

  task automatic collect(output logic [9:0] g);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); slot_i = 1;
      #1 g[i] = frm_ack_o;
      @(posedge clk); #1 slot_i = 0;
    end
  endtask

  task automatic expect_next(input string req, input logic [7:0] fid);
    logic v; logic [7:0] f; longint d;
    emit(v, f, d);
    check(req, longint'(v), 1);
    check(req, longint'(f), longint'(fid));
    check(req, d, 1000 + longint'(fid));
  endtask

  task automatic t_reset();
    logic v; logic [7:0] f; longint d;
    do_reset();
    @(negedge clk); #1;
    check("R1 ready", longint'(tx_ready_o), 1);
    check("R1 ack bit", longint'(frm_ack_o), 0);
    check("R1 err count", longint'(crc_err_cnt_o), 0);
    emit(v, f, d);
    check("R1 empty store", longint'(v), 0);
  endtask

  task automatic t_order();
    logic r, v; logic [7:0] f; longint d;
    do_reset();
    for (int k = 0; k < 5; k++) push(k, r);
    for (int k = 0; k < 5; k++) expect_next("R2 order", 8'(k));
    emit(v, f, d);
    check("R2 drained", longint'(v), 0);
  endtask

  task automatic t_ack_replay();
    logic r, v; logic [7:0] f; longint d; int acc;
    do_reset();
    for (int k = 0; k < 5; k++) push(k, r);
    for (int k = 0; k < 5; k++) emit(v, f, d);
    send_group(8'd2, 1'b0, -1);
    send_group(8'hFF, 1'b1, -1);
    expect_next("R4 R5 rewind to oldest", 8'd3);
    expect_next("R5 continue", 8'd4);
    send_group(8'd1, 1'b0, -1);
    send_group(8'hFF, 1'b1, -1);
    expect_next("R4 older ack ignored", 8'd3);
    send_group(8'd203, 1'b0, -1);
    send_group(8'hFF, 1'b1, -1);
    expect_next("R4 far ack ignored", 8'd3);
    send_group(8'd4, 1'b0, 9);
    send_group(8'hFF, 1'b1, -1);
    expect_next("R6 corrupt ack dropped", 8'd3);
    send_group(8'd4, 1'b0, -1);
    emit(v, f, d);
    check("R4 cumulative release", longint'(v), 0);
    acc = 0;
    for (int k = 5; k < 39; k++) begin
      push(k, r);
      if (r) acc++;
    end
    check("R3 capacity", longint'(acc), 32);
    @(negedge clk); #1 check("R3 ready low when full", longint'(tx_ready_o), 0);
    expect_next("R2 after refill", 8'd5);
    send_group(8'd5, 1'b0, -1);
    @(negedge clk); #1 check("R3 ready after release", longint'(tx_ready_o), 1);
  endtask

  task automatic t_rx_accept();
    logic a;
    do_reset();
    rx_frame(8'd0, 1, 1, a); check("R7 expected accepted", longint'(a), 1);
    rx_frame(8'd3, 1, 1, a); check("R7 wrong id dropped", longint'(a), 0);
    rx_frame(8'd1, 1, 0, a); check("R7 non-ack frame", longint'(a), 0);
    rx_frame(8'd1, 1, 1, a); check("R7 next accepted", longint'(a), 1);
  endtask

  task automatic t_ack_out();
    logic a; logic [9:0] g;
    do_reset();
    for (int k = 0; k < 6; k++) rx_frame(8'(k), 1, 1, a);
    collect(g); check("R8 first group", longint'(g), longint'({1'b0, 8'd0, 1'b1}));
    collect(g); check("R8 newest group", longint'(g), longint'({1'b0, 8'd5, 1'b1}));
    collect(g); check("R8 idle zero", longint'(g), 0);
  endtask

  task automatic t_replay_req();
    logic a; logic [9:0] g;
    do_reset();
    rx_frame(8'd0, 0, 1, a);
    collect(g); check("R9 replay group", longint'(g), 1023);
    rx_frame(8'd0, 0, 1, a);
    collect(g); check("R9 single request", longint'(g), 0);
    rx_frame(8'd0, 1, 1, a);
    rx_frame(8'd1, 1, 1, a);
    rx_frame(8'd2, 0, 1, a);
    collect(g); check("R9 ack in flight", longint'(g), longint'({1'b0, 8'd0, 1'b1}));
    collect(g); check("R9 replay first", longint'(g), 1023);
    collect(g); check("R9 ack after replay", longint'(g), longint'({1'b0, 8'd1, 1'b1}));
    check("R10 count", longint'(crc_err_cnt_o), 3);
  endtask

  task automatic t_saturate();
    do_reset();
    @(negedge clk); rx_slot_i = 1; rx_crc_ok_i = 0;
    repeat (65540) @(negedge clk);
    rx_slot_i = 0;
    #1 check("R10 saturation", longint'(crc_err_cnt_o), 65535);
  endtask

  initial begin
    t_reset();
    t_order();
    t_ack_replay();
    t_rx_accept();
    t_ack_out();
    t_replay_req();
    t_saturate();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule